// File: doc/BRIEF.md
# Bus Priority Contention Unit

This block sits between a frame sequencer and the line driver of a node on a wired-AND field bus, where a 0 bit is dominant. During the priority window, the sequencer presents one bit per bit time. This covers the eleven identifier bits, most significant first, followed by the request-type bit. At each sample strobe the unit compares the level it drives with the level read back from the bus. If the node drives recessive but reads dominant, another node holds a numerically lower priority key. The node then silently releases the line and continues as a listener. A node that never sees such a mismatch gets through the window untouched and is told that it won.

Outside the priority window the same comparison becomes a bit-error detector, except during the acknowledge slot. The unit also counts consecutive recessive samples to decide when the bus is free again. A node that withdrew is re-armed by a one-cycle retry pulse once that free condition is reached, so the sequencer can start the frame again. Framing, checksum and bit stuffing belong to other blocks.

Top module: `can_arb_unit`

## Requirements
- R1: After reset, tx_pin follows tx_bit, and arb_lost, arb_won, bit_err, retry, withdrawn and bus_idle are all 0.
- R2: While the node is not withdrawn, tx_pin equals tx_bit combinationally.
- R3: A strobe with arb_en=1 where tx_pin=1 (recessive) and rx_bit=0 (dominant) raises arb_lost for exactly the one cycle after that strobe edge and sets withdrawn from that cycle on.
- R4: While withdrawn=1, tx_pin is 1 whatever tx_bit is.
- R5: After ARB_BITS (default 12) window strobes with no loss, arb_won pulses for one cycle right after the last of those strobes. It does not pulse if the node lost on that last strobe.
- R6: Among contending nodes the lowest 12-bit key {identifier, request bit} wins, and the bus carries exactly that key. A data frame (request bit 0) beats a remote request (request bit 1) with the same identifier.
- R7: Outside the window, with tx_active=1, a mismatch in either direction raises bit_err for one cycle and never arb_lost. It is silent when ack_slot=1 or tx_active=0.
- R8: Inside the window, driving dominant (0) but reading recessive (1) raises bit_err, not arb_lost.
- R9: bus_idle rises after IDLE_BITS (default 11) consecutive recessive strobes and falls after any dominant strobe.
- R10: A withdrawn node gets a one-cycle retry pulse right after the strobe that completes the idle run, and withdrawn clears at that same edge. A non-withdrawn node gets no retry.
- R11: While withdrawn, mismatches produce no further arb_lost, arb_won or bit_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe at the bit sample point |
| arb_en | input | 1 | High during the priority window bits |
| tx_active | input | 1 | Sequencer is sending a frame |
| ack_slot | input | 1 | Current bit is the acknowledge slot |
| tx_bit | input | 1 | Bit the sequencer wants on the bus |
| rx_bit | input | 1 | Bus level at the sample point |
| tx_pin | output | 1 | Level driven to the line driver |
| arb_lost | output | 1 | One-cycle pulse: priority lost |
| arb_won | output | 1 | One-cycle pulse: window completed without loss |
| bit_err | output | 1 | One-cycle pulse: bit error detected |
| withdrawn | output | 1 | Node is listening only |
| bus_idle | output | 1 | Idle run of recessive samples reached |
| retry | output | 1 | One-cycle pulse: withdrawn node may restart |

## Verification
tx_pin is combinational, so it is checked in the same cycle in which tx_bit changes. Every other result is registered once from the strobe edge. arb_lost, arb_won, bit_err and retry are therefore valid only in the single cycle after the strobe that caused them, and withdrawn and bus_idle change on that same edge. Each step of the bench drives its inputs and one strobe at a falling edge and then waits one rising edge. At the next falling edge it reads the outputs, before it drives the next bit. Arbitration scenarios run up to three node keys through a bus that is the AND of all nodes. The bench checks the pulse counts, the key seen on the bus and the retry position.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;

  // contention state of the local node
  typedef enum logic {
    ST_CONTEND = 1'b0,
    ST_LISTEN  = 1'b1
  } arb_st_e;

  // per-strobe events produced by the comparator
  typedef struct packed {
    logic lose;
    logic win;
    logic err;
  } arb_evt_t;

endpackage

// File: rtl/can_arb_rst_sync.sv
module can_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/can_arb_idle.sv
module can_arb_idle #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic rx_bit,
  output logic bus_idle,
  output logic idle_hit
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(IDLE_BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (smp_stb) begin
      if (!rx_bit)              run_d = '0;
      else if (run_q != CNT_MAX) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // strobe that completes the recessive run
  assign idle_hit = smp_stb & rx_bit & (run_q == CNT_LAST);
  assign bus_idle = (run_q == CNT_MAX);

  AST_IDLE_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CNT_MAX); // R9
  AST_IDLE_DOM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !rx_bit) |=> !bus_idle); // R9
  AST_IDLE_HIT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> bus_idle); // R9
endmodule

// File: rtl/can_arb_cmp.sv
module can_arb_cmp
  import can_arb_pkg::*;
#(
  parameter int ARB_BITS = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     smp_stb,
  input  logic     arb_en,
  input  logic     tx_active,
  input  logic     ack_slot,
  input  logic     contend,
  input  logic     tx_pin,
  input  logic     rx_bit,
  output arb_evt_t evt
);
  localparam int BW = $clog2(ARB_BITS + 1);
  localparam logic [BW-1:0] POS_END  = BW'(ARB_BITS);
  localparam logic [BW-1:0] POS_LAST = BW'(ARB_BITS - 1);

  logic [BW-1:0] pos_q, pos_d;
  logic          rec_read_dom, dom_read_rec, live_stb, last_bit;

  // window bit position, held at the end value if the window runs long
  always_comb begin
    pos_d = pos_q;
    if (!arb_en)                          pos_d = '0;
    else if (smp_stb && pos_q != POS_END) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign rec_read_dom = tx_pin & ~rx_bit;
  assign dom_read_rec = ~tx_pin & rx_bit;
  assign live_stb     = smp_stb & contend;
  assign last_bit     = (pos_q == POS_LAST);

  always_comb begin
    evt      = '0;
    evt.lose = live_stb & arb_en & rec_read_dom;
    evt.win  = live_stb & arb_en & last_bit & ~rec_read_dom;
    evt.err  = live_stb & ((arb_en & dom_read_rec) |
               (~arb_en & tx_active & ~ack_slot & (rec_read_dom | dom_read_rec)));
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_END); // R5
  AST_LOSE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.lose && evt.err)); // R8
  AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (pos_q == '0)); // R5
endmodule

// File: rtl/can_arb_ctrl.sv
module can_arb_ctrl
  import can_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  arb_evt_t evt,
  input  logic     idle_hit,
  output logic     contend,
  output logic     withdrawn,
  output logic     arb_lost,
  output logic     arb_won,
  output logic     bit_err,
  output logic     retry
);
  arb_st_e st_q, st_d;
  logic    lost_q, won_q, err_q, retry_q;
  logic    retry_d;

  always_comb begin
    st_d    = st_q;
    retry_d = 1'b0;
    case (st_q)
      ST_CONTEND: if (evt.lose) st_d = ST_LISTEN;
      ST_LISTEN: begin
        if (idle_hit) begin
          st_d    = ST_CONTEND;
          retry_d = 1'b1;
        end
      end
      default: st_d = ST_CONTEND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CONTEND;
      lost_q  <= 1'b0;
      won_q   <= 1'b0;
      err_q   <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      lost_q  <= evt.lose;
      won_q   <= evt.win;
      err_q   <= evt.err;
      retry_q <= retry_d;
    end
  end

  assign contend   = (st_q == ST_CONTEND);
  assign withdrawn = (st_q == ST_LISTEN);
  assign arb_lost  = lost_q;
  assign arb_won   = won_q;
  assign bit_err   = err_q;
  assign retry     = retry_q;

  AST_LOSS_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.lose |=> (withdrawn && arb_lost)); // R3
  AST_LOST_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost); // R3
  AST_WON_LOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_won && arb_lost)); // R5
  AST_RETRY_REJOINS: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !withdrawn); // R10
  AST_LISTEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (withdrawn && $past(withdrawn)) |-> (!arb_won && !bit_err && !arb_lost)); // R11
endmodule

// File: rtl/can_arb_unit.sv
module can_arb_unit
  import can_arb_pkg::*;
#(
  parameter int ID_BITS   = 11,
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic arb_en,
  input  logic tx_active,
  input  logic ack_slot,
  input  logic tx_bit,
  input  logic rx_bit,
  output logic tx_pin,
  output logic arb_lost,
  output logic arb_won,
  output logic bit_err,
  output logic withdrawn,
  output logic bus_idle,
  output logic retry
);
  // identifier bits plus the request-type bit
  localparam int ARB_BITS = ID_BITS + 1;

  logic     rst_n_i, contend, idle_hit;
  arb_evt_t evt;

  can_arb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  can_arb_idle #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n_i), .smp_stb(smp_stb), .rx_bit(rx_bit),
    .bus_idle(bus_idle), .idle_hit(idle_hit)
  );

  can_arb_cmp #(.ARB_BITS(ARB_BITS)) u_cmp (
    .clk(clk), .rst_n(rst_n_i), .smp_stb(smp_stb), .arb_en(arb_en),
    .tx_active(tx_active), .ack_slot(ack_slot), .contend(contend),
    .tx_pin(tx_pin), .rx_bit(rx_bit), .evt(evt)
  );

  can_arb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .evt(evt), .idle_hit(idle_hit),
    .contend(contend), .withdrawn(withdrawn), .arb_lost(arb_lost),
    .arb_won(arb_won), .bit_err(bit_err), .retry(retry)
  );

  // a withdrawn node releases the line to recessive
  assign tx_pin = contend ? tx_bit : 1'b1;

  AST_LOST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n_i)
    arb_lost |-> $past(arb_en && smp_stb)); // R7
  AST_WITHDRAWN_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n_i)
    withdrawn |-> tx_pin); // R4
  AST_LOST_SAW_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n_i)
    arb_lost |-> !$past(rx_bit)); // R3
endmodule

// File: tb/can_arb_unit_tb.sv
module can_arb_unit_tb;
  logic clk, rst_n, smp_stb, arb_en, tx_active, ack_slot, tx_bit, rx_bit;
  logic tx_pin, arb_lost, arb_won, bit_err, withdrawn, bus_idle, retry;
  logic oth_bus, frc_rec;
  int   n_chk, n_fail;
  bit   done;

  // wired-AND bus of the DUT and the modelled nodes; frc_rec injects a fault
  assign rx_bit = frc_rec ? 1'b1 : (tx_pin & oth_bus);

  can_arb_unit u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .arb_en(arb_en),
    .tx_active(tx_active), .ack_slot(ack_slot), .tx_bit(tx_bit),
    .rx_bit(rx_bit), .tx_pin(tx_pin), .arb_lost(arb_lost),
    .arb_won(arb_won), .bit_err(bit_err), .withdrawn(withdrawn),
    .bus_idle(bus_idle), .retry(retry)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // one bit time: drive at a falling edge, strobe across one rising edge,
  // return at the next falling edge where the registered results are valid
  task automatic step(input logic tb, input logic ob, input logic win,
                      input logic act, input logic ack, output logic bus_v);
    tx_bit = tb; oth_bus = ob; arb_en = win; tx_active = act; ack_slot = ack;
    smp_stb = 1'b1;
    #1 bus_v = rx_bit;
    @(posedge clk);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // one dominant bit then n recessive bits; checks idle and retry timing
  task automatic idle_bus(input int n, input logic was_wd);
    logic bv;
    int   retry_at;
    retry_at = -1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, bv);
    chk("R9", "bus_idle after dominant", bus_idle, 0);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, bv);
      if (retry) retry_at = i;
      if (i == 9) chk("R9", "bus_idle after 10 recessive", bus_idle, 0);
      if (i == 10) begin
        chk("R9", "bus_idle after 11 recessive", bus_idle, 1);
        chk("R10", "withdrawn after idle run", withdrawn, 0);
      end
    end
    chk("R10", "retry position", retry_at, was_wd ? 10 : -1);
  endtask

  // arbitration of the DUT against one or two modelled nodes
  task automatic run_arb(input string name, input logic [11:0] k_dut,
                         input logic [11:0] k_a, input logic [11:0] k_b,
                         input logic use_b);
    logic [11:0] busw, kmin;
    logic        a_out, b_out, bv, dut_wins;
    int          n_lost, n_won, n_err, bad_pin;
    a_out = 0; b_out = 0; n_lost = 0; n_won = 0; n_err = 0; bad_pin = 0;
    kmin = (k_a < k_dut) ? k_a : k_dut;
    if (use_b && k_b < kmin) kmin = k_b;
    dut_wins = (kmin == k_dut);
    for (int i = 11; i >= 0; i--) begin
      logic ob;
      ob = (a_out | k_a[i]) & (b_out | ~use_b | k_b[i]);
      tx_bit = k_dut[i];
      #1;
      if (withdrawn && tx_pin !== 1'b1) bad_pin++;
      step(k_dut[i], ob, 1'b1, 1'b1, 1'b0, bv);
      busw[i] = bv;
      if (k_a[i] && !bv) a_out = 1;
      if (use_b && k_b[i] && !bv) b_out = 1;
      n_lost += int'(arb_lost);
      n_won  += int'(arb_won);
      n_err  += int'(bit_err);
    end
    arb_en = 1'b0;
    chk("R6", {name, " key on bus"}, busw, kmin);
    chk("R5", {name, " won pulses"}, n_won, dut_wins ? 1 : 0);
    chk("R3", {name, " lost pulses"}, n_lost, dut_wins ? 0 : 1);
    chk("R3", {name, " withdrawn"}, withdrawn, !dut_wins);
    chk("R11", {name, " no error"}, n_err, 0);
    chk("R4", {name, " recessive when out"}, bad_pin, 0);
    if (!dut_wins) begin
      tx_bit = 1'b0;
      #1 chk("R4", {name, " tx_pin with tx_bit 0"}, tx_pin, 1);
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, bv);
      chk("R11", {name, " mismatch while out"}, bit_err, 0);
    end
    idle_bus(11, !dut_wins);
  endtask

  task automatic t_reset;
    chk("R1", "tx_pin", tx_pin, 1);
    chk("R1", "flags", {arb_lost, arb_won, bit_err, retry, withdrawn, bus_idle}, 0);
  endtask

  task automatic t_follow;
    tx_bit = 1'b0; #1 chk("R2", "tx_pin low", tx_pin, 0);
    tx_bit = 1'b1; #1 chk("R2", "tx_pin high", tx_pin, 1);
  endtask

  task automatic t_biterr;
    logic bv;
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, bv);
    chk("R7", "rec read dom err", bit_err, 1);
    chk("R7", "no loss outside window", {arb_lost, withdrawn}, 0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, bv);
    chk("R7", "ack slot silent", bit_err, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, bv);
    chk("R7", "inactive silent", bit_err, 0);
    frc_rec = 1'b1;
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, bv);
    chk("R7", "dom read rec err", bit_err, 1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, bv);
    chk("R8", "window dom read rec err", bit_err, 1);
    chk("R8", "window dom read rec no loss", {arb_lost, withdrawn}, 0);
    frc_rec = 1'b0;
    arb_en = 1'b0;
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, bv);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; smp_stb = 0; arb_en = 0; tx_active = 0; ack_slot = 0;
    tx_bit = 1'b1; oth_bus = 1'b1; frc_rec = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_follow();
    idle_bus(11, 1'b0);
    t_biterr();
    run_arb("low wins", {11'h100, 1'b0}, {11'h200, 1'b0}, {11'h300, 1'b1}, 1'b1);
    run_arb("lose last id bit", {11'h155, 1'b0}, {11'h154, 1'b0}, {11'h7FF, 1'b0}, 1'b1);
    run_arb("data beats remote", {11'h0A5, 1'b0}, {11'h0A5, 1'b1}, 12'hFFF, 1'b0);
    run_arb("remote loses", {11'h0A5, 1'b1}, {11'h0A5, 1'b0}, 12'hFFF, 1'b0);
    run_arb("three nodes", {11'h400, 1'b0}, {11'h3FF, 1'b0}, {11'h010, 1'b0}, 1'b1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule